// File: doc/BRIEF.md
# Bulk Receive Stream Packet Splitter

This block sits behind the receive endpoint of a USB-attached Ethernet adapter. One bulk-in transfer buffer can carry several Ethernet packets one after another. Each packet opens with three header bytes and closes with its four-byte frame check sequence. The header holds a status byte, then a 16-bit length sent low byte first. The length counts the FCS as well as the payload. The splitter takes the buffer one byte at a time. A marker on the input flags the final byte of each buffer. The block removes the header and the FCS and sends each payload out as its own frame, with a valid strobe, a last flag and an error flag.

The splitter checks each header. A bad status byte or an impossible length means the rest of the buffer cannot be trusted, so the block consumes everything up to the end-of-buffer marker and sends nothing out. A buffer that ends partway through a packet's payload closes the frame with the error flag. A buffer that ends inside a header produces no output. The block does not verify the CRC, and there is no back-pressure: an accepted byte shows up at the output on the next cycle or not at all.

Top module: `bulk_rx_splitter`

## Requirements
- R1: While reset is held and on the first cycle after it, `outValid`, `outLast` and `outErr` are low.
- R2: Each packet starts with a status byte, which must be 0x40 to be accepted. Next come the length low byte and then the length high byte. None of these three header bytes is forwarded, and the frame carries exactly (length - 4) payload bytes in order.
- R3: The four FCS bytes after the payload are consumed and not forwarded. `outLast` is high on the final payload byte only, and `outErr` stays low for a complete frame.
- R4: Packets placed back to back in one buffer come out as separate frames, in order, with no bytes lost or merged between them.
- R5: A payload of 1514 bytes (length field 1518) is accepted and forwarded in full. No frame ever exceeds 1514 bytes.
- R6: A length field of exactly 4 gives an empty packet: no output, its four FCS bytes are consumed, and the next byte is parsed as a new status byte.
- R7: A status byte other than 0x40 drops every remaining byte of the buffer, up to and including the byte marked end-of-buffer, with no output. The next byte starts a fresh header.
- R8: A length field above 1518 or below 4 drops the rest of the buffer in the same way as R7.
- R9: A buffer that ends on a status byte or a length byte produces no output. The next byte is taken as a status byte.
- R10: If the end-of-buffer marker arrives on a payload byte before the declared payload is complete, that byte is forwarded with `outLast` and `outErr` both high.
- R11: If the end-of-buffer marker arrives inside the FCS, the already-completed frame stays error-free and the next byte starts a fresh header.
- R12: Cycles with `inValid` low change nothing. An output byte appears exactly one cycle after the input byte it comes from is accepted, and never in a cycle that follows an idle input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 8 | Input stream byte |
| inValid | input | 1 | Input byte present this cycle |
| inEob | input | 1 | Input byte is the final byte of its transfer buffer |
| outData | output | 8 | Payload byte |
| outValid | output | 1 | Payload byte present this cycle |
| outLast | output | 1 | Final byte of the frame |
| outErr | output | 1 | Frame was cut short; valid with outLast |

## Verification
Single packets and multi-packet buffers with payload sizes of 1, 10, 60 and 1514 bytes show whether the length arithmetic and the FCS skip keep frame boundaries exact. Buffers whose bytes are spread out by idle cycles check that gaps neither shift nor duplicate output. Malformed buffers hide a well-formed header behind a bad status byte or an out-of-range length: any output from that hidden header shows the drop did not run to the marker. Buffers that end inside a header, inside a payload and inside an FCS, each followed by a clean buffer, separate the three truncation outcomes and show that parsing restarts cleanly.

// File: rtl/bulk_rx_splitter_pkg.sv
package bulk_rx_splitter_pkg;

  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_STAT,
    ST_LENLO,
    ST_LENHI,
    ST_PAY,
    ST_FCS,
    ST_DRAIN
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capLo;     // store length low byte
    logic loadPay;   // load payload byte counter
    logic loadFcs;   // load trailer byte counter
    logic dec;       // count one byte down
    logic emit;      // forward current byte
    logic emitLast;  // forwarded byte closes the frame
    logic emitErr;   // forwarded byte closes a cut-short frame
  } pathCmd_t;

endpackage

// File: rtl/bulk_rx_splitter_path.sv
module bulk_rx_splitter_path
  import bulk_rx_splitter_pkg::*;
#(
  parameter int MAX_PAYLOAD = 1514,
  parameter int FCS_LEN     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] inData,
  input  pathCmd_t          cmd,
  output logic              lenBad,
  output logic              lenZero,
  output logic              cntLast,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic              outErr
);

  localparam logic [LEN_W-1:0] FCS_L     = LEN_W'(FCS_LEN);
  localparam logic [LEN_W-1:0] MAX_FIELD = LEN_W'(MAX_PAYLOAD + FCS_LEN);

  logic [BYTE_W-1:0] lenLo;
  logic [LEN_W-1:0]  rawLen;
  logic [LEN_W-1:0]  remain;

  // the high byte arrives on the cycle the length is judged
  assign rawLen  = {inData, lenLo};
  assign lenBad  = (rawLen < FCS_L) || (rawLen > MAX_FIELD);
  assign lenZero = (rawLen == FCS_L);
  assign cntLast = (remain == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lenLo  <= '0;
      remain <= '0;
    end else begin
      if (cmd.capLo) lenLo <= inData;
      if (cmd.loadPay)      remain <= rawLen - FCS_L;
      else if (cmd.loadFcs) remain <= FCS_L;
      else if (cmd.dec)     remain <= remain - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      outValid <= cmd.emit;
      outLast  <= cmd.emit & cmd.emitLast;
      outErr   <= cmd.emit & cmd.emitErr;
      if (cmd.emit) outData <= inData;
    end
  end

endmodule

// File: rtl/bulk_rx_splitter_ctrl.sv
module bulk_rx_splitter_ctrl
  import bulk_rx_splitter_pkg::*;
#(
  parameter logic [BYTE_W-1:0] GOOD_STATUS = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inEob,
  input  logic              lenBad,
  input  logic              lenZero,
  input  logic              cntLast,
  output pathCmd_t          cmd,
  output splitState_t       state
);

  splitState_t nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_STAT;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (inValid) begin
      case (state)
        ST_STAT: begin
          if (inEob)                       nextState = ST_STAT;
          else if (inData != GOOD_STATUS)  nextState = ST_DRAIN;
          else                             nextState = ST_LENLO;
        end
        ST_LENLO: begin
          cmd.capLo = 1'b1;
          nextState = inEob ? ST_STAT : ST_LENHI;
        end
        ST_LENHI: begin
          if (inEob) begin
            nextState = ST_STAT;
          end else if (lenBad) begin
            nextState = ST_DRAIN;
          end else if (lenZero) begin
            cmd.loadFcs = 1'b1;
            nextState   = ST_FCS;
          end else begin
            cmd.loadPay = 1'b1;
            nextState   = ST_PAY;
          end
        end
        ST_PAY: begin
          cmd.emit = 1'b1;
          if (cntLast) begin
            cmd.emitLast = 1'b1;
            if (inEob) begin
              nextState = ST_STAT;
            end else begin
              cmd.loadFcs = 1'b1;
              nextState   = ST_FCS;
            end
          end else if (inEob) begin
            cmd.emitLast = 1'b1;
            cmd.emitErr  = 1'b1;
            nextState    = ST_STAT;
          end else begin
            cmd.dec = 1'b1;
          end
        end
        ST_FCS: begin
          cmd.dec = 1'b1;
          if (cntLast || inEob) nextState = ST_STAT;
        end
        ST_DRAIN: begin
          if (inEob) nextState = ST_STAT;
        end
        default: nextState = ST_STAT;
      endcase
    end
  end

endmodule

// File: rtl/bulk_rx_splitter.sv
module bulk_rx_splitter
  import bulk_rx_splitter_pkg::*;
#(
  parameter int                MAX_PAYLOAD = 1514,
  parameter int                FCS_LEN     = 4,
  parameter logic [BYTE_W-1:0] GOOD_STATUS = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inEob,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic              outErr
);

  pathCmd_t    cmd;
  splitState_t ctrlState;
  logic        lenBad;
  logic        lenZero;
  logic        cntLast;

  bulk_rx_splitter_ctrl #(
    .GOOD_STATUS(GOOD_STATUS)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .inData (inData),
    .inValid(inValid),
    .inEob  (inEob),
    .lenBad (lenBad),
    .lenZero(lenZero),
    .cntLast(cntLast),
    .cmd    (cmd),
    .state  (ctrlState)
  );

  bulk_rx_splitter_path #(
    .MAX_PAYLOAD(MAX_PAYLOAD),
    .FCS_LEN    (FCS_LEN)
  ) path_i (
    .clk     (clk),
    .rst     (rst),
    .inData  (inData),
    .cmd     (cmd),
    .lenBad  (lenBad),
    .lenZero (lenZero),
    .cntLast (cntLast),
    .outData (outData),
    .outValid(outValid),
    .outLast (outLast),
    .outErr  (outErr)
  );

endmodule

// File: rtl/bulk_rx_splitter_checker.sv
module bulk_rx_splitter_checker
  import bulk_rx_splitter_pkg::*;
#(
  parameter int MAX_PAYLOAD = 1514
) (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        outValid,
  input logic        outLast,
  input logic        outErr,
  input splitState_t ctrlState
);

  logic [31:0] frameCnt;

  always_ff @(posedge clk) begin
    if (rst)                frameCnt <= '0;
    else if (outValid)      frameCnt <= outLast ? '0 : frameCnt + 32'd1;
  end

  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

  assert_err_closes_frame_R10: assert property (@(posedge clk) disable iff (rst)
    outErr |-> outLast);

  assert_idle_no_output_R12: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  assert_drain_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_DRAIN) |=> !outValid);

  assert_overhead_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrlState inside {ST_STAT, ST_LENLO, ST_LENHI, ST_FCS}) |=> !outValid);

  assert_frame_bound_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (frameCnt < 32'(MAX_PAYLOAD)));

endmodule

bind bulk_rx_splitter bulk_rx_splitter_checker #(
  .MAX_PAYLOAD(MAX_PAYLOAD)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outLast  (outLast),
  .outErr   (outErr),
  .ctrlState(ctrlState)
);

// File: tb/bulk_rx_splitter_tb.sv
module bulk_rx_splitter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inEob = 1'b0;
  logic [7:0] outData;
  logic       outValid;
  logic       outLast;
  logic       outErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] bufQ[$];
  logic [9:0] expQ[$];   // {err, last, data}
  string      tagQ[$];

  always #5 clk = ~clk;

  bulk_rx_splitter dut_i (
    .clk     (clk),
    .rst     (rst),
    .inData  (inData),
    .inValid (inValid),
    .inEob   (inEob),
    .outData (outData),
    .outValid(outValid),
    .outLast (outLast),
    .outErr  (outErr)
  );

  // monitor: compare each output byte against the scoreboard
  always @(negedge clk) begin
    if (!rst && outValid && !done) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected output: actual %h expected none", {outErr, outLast, outData});
      end else begin
        automatic logic [9:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if ({outErr, outLast, outData} !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, {outErr, outLast, outData}, e);
        end
      end
    end
  end

  function automatic logic [7:0] payByte(int seed, int i);
    return 8'((seed + i * 7) & 8'hFF);
  endfunction

  task automatic putHdr(input logic [7:0] st, input int field);
    bufQ.push_back(st);
    bufQ.push_back(8'(field & 8'hFF));
    bufQ.push_back(8'((field >> 8) & 8'hFF));
  endtask

  task automatic putPay(input int n, input int seed, input bit expect_, input bit errEnd, input string tag);
    for (int i = 0; i < n; i++) begin
      bufQ.push_back(payByte(seed, i));
      if (expect_) begin
        expQ.push_back({errEnd && (i == n - 1), i == n - 1, payByte(seed, i)});
        tagQ.push_back(tag);
      end
    end
  endtask

  task automatic putRaw(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) bufQ.push_back(base + 8'(i));
  endtask

  task automatic goodPkt(input int n, input int seed, input string tag);
    putHdr(8'h40, n + 4);
    putPay(n, seed, 1'b1, 1'b0, tag);
    putRaw(4, 8'hC0);
  endtask

  task automatic sendBuf(input bit gaps);
    for (int i = 0; i < bufQ.size(); i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); #1;
        inValid = 1'b0;
        inEob   = 1'b0;
        inData  = 8'h40;
      end
      @(posedge clk); #1;
      inValid = 1'b1;
      inData  = bufQ[i];
      inEob   = (i == bufQ.size() - 1);
    end
    @(posedge clk); #1;
    inValid = 1'b0;
    inEob   = 1'b0;
    bufQ.delete();
  endtask

  task automatic settle(input string tag);
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d outstanding bytes expected 0", tag, expQ.size());
      expQ.delete();
      tagQ.delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({outValid, outLast, outErr} !== 3'b000) begin
      errors++;
      $display("FAIL R1 in reset: actual %b expected 000", {outValid, outLast, outErr});
    end
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({outValid, outLast, outErr} !== 3'b000) begin
      errors++;
      $display("FAIL R1 after reset: actual %b expected 000", {outValid, outLast, outErr});
    end

    // R2 R3: one packet
    goodPkt(10, 3, "R2");
    sendBuf(1'b0);
    settle("R3");

    // R4 R5: several packets in one buffer, including maximum size
    goodPkt(1, 20, "R4");
    goodPkt(60, 90, "R4");
    goodPkt(1514, 5, "R5");
    goodPkt(2, 77, "R4");
    sendBuf(1'b0);
    settle("R5");

    // R6: empty packet then a normal one
    putHdr(8'h40, 4);
    putRaw(4, 8'hD0);
    goodPkt(7, 11, "R6");
    sendBuf(1'b0);
    settle("R6");

    // R7: bad status hides a well-formed packet
    goodPkt(5, 33, "R7");
    putHdr(8'h41, 10);
    putHdr(8'h40, 8);
    putPay(8, 1, 1'b0, 1'b0, "R7");
    putRaw(4, 8'hC0);
    sendBuf(1'b0);
    goodPkt(4, 44, "R7");
    sendBuf(1'b0);
    settle("R7");

    // R8: length too large, then too small
    goodPkt(3, 55, "R8");
    putHdr(8'h40, 1519);
    putHdr(8'h40, 6);
    putPay(2, 9, 1'b0, 1'b0, "R8");
    putRaw(20, 8'h10);
    sendBuf(1'b0);
    putHdr(8'h40, 3);
    putHdr(8'h40, 6);
    putPay(2, 9, 1'b0, 1'b0, "R8");
    putRaw(4, 8'hC0);
    sendBuf(1'b0);
    goodPkt(6, 66, "R8");
    sendBuf(1'b0);
    settle("R8");

    // R9: buffers ending inside a header
    bufQ.push_back(8'h40);
    bufQ.push_back(8'h08);
    sendBuf(1'b0);
    bufQ.push_back(8'h40);
    sendBuf(1'b0);
    putHdr(8'h40, 9);
    sendBuf(1'b0);
    goodPkt(3, 71, "R9");
    sendBuf(1'b0);
    settle("R9");

    // R10: payload cut short by the end marker
    goodPkt(4, 12, "R10");
    putHdr(8'h40, 24);
    putPay(5, 200, 1'b1, 1'b1, "R10");
    sendBuf(1'b0);
    goodPkt(3, 81, "R10");
    sendBuf(1'b0);
    settle("R10");

    // R11: end marker inside the trailer
    putHdr(8'h40, 9 + 4);
    putPay(9, 130, 1'b1, 1'b0, "R11");
    putRaw(2, 8'hC0);
    sendBuf(1'b0);
    goodPkt(5, 140, "R11");
    sendBuf(1'b0);
    settle("R11");

    // R12: idle gaps between input bytes
    goodPkt(12, 150, "R12");
    goodPkt(1, 160, "R12");
    sendBuf(1'b1);
    putHdr(8'h40, 30);
    putPay(4, 170, 1'b1, 1'b1, "R12");
    sendBuf(1'b1);
    settle("R12");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule